// File: doc/BRIEF.md
# PLL Operating-Mode Controller

This block picks the operating mode of a telecom timing PLL. The three modes are Normal (tracking a reference), Holdover (replaying the last good frequency) and Freerun. It also picks which of two references feeds the input mux. It tells the TIE corrector when a reference change needs phase realignment. It asks an external guard-time timer to start when a failover to the secondary reference is pending.

A two-bit strap chooses the control style. Three of its codes fix a single mode by hand, and a separate select input names the reference. The fourth code hands control to an automatic sequence. That sequence watches the loss-of-signal flags of both references and the guard-time expiry input. It fails over from primary to secondary through Holdover. It returns to the primary as soon as the primary is healthy again.

No decision is taken on every system clock. The controller samples its inputs only on the rising edge of the 8 kHz frame pulse, and its registered outputs change in the clock cycle that follows that edge.

Top module: `pll_mode_ctrl`

## Requirements
- R1: While `rst_n` is low, and after its release until the first frame edge, the outputs are `pll_mode`=2'b10 (Freerun), `ref_sel`=0, `tie_en`=0 and `gt_start`=0.
- R2: A frame edge is a clock cycle in which `frm` is high and was low in the previous cycle. The outputs take new values only on the clock edge that ends a frame-edge cycle. In every other cycle they hold, whatever the inputs do.
- R3: Mode codes are 2'b00 Normal, 2'b01 Holdover and 2'b10 Freerun. With `msel` at 2'b00, 2'b01 or 2'b10, a frame edge sets `pll_mode` to the value of `msel`. `pll_mode` never shows 2'b11.
- R4: Under manual control (`msel` not 2'b11), `ref_sel` loads `ref_req` only on a frame edge that selects Normal. On any other frame edge it keeps its value.
- R5: With `msel`=2'b11, a frame edge with `los_pri`=0 gives Normal with `ref_sel`=0 (the primary reference).
- R6: With `msel`=2'b11, a frame edge with `los_pri`=1 and `los_sec`=0 gives Holdover with `gt_start`=1 and `ref_sel` unchanged. Two cases are excluded: the block is already in Normal on `ref_sel`=1, or the conditions of R7 hold.
- R7: With `msel`=2'b11, `los_pri`=1 and `los_sec`=0, a frame edge that finds `gt_start`=1 and `gt_done`=1 gives Normal with `ref_sel`=1. If the block is already in Normal with `ref_sel`=1, it stays there.
- R8: With `msel`=2'b11 and both loss flags at 1, a frame edge gives Holdover with `gt_start`=0 and `ref_sel` unchanged.
- R9: `tie_en` is 1 for exactly one frame period, from one frame edge to the next, after a frame edge that leaves the block in Normal with a `ref_sel` different from its previous value. After any other frame edge it is 0.
- R10: `gt_start` is 1 only while `pll_mode` is Holdover.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm | input | 1 | 8 kHz frame pulse, synchronous to `clk` |
| msel | input | 2 | Control strap: 00 Normal, 01 Holdover, 10 Freerun, 11 automatic |
| ref_req | input | 1 | Manual reference choice (0 primary, 1 secondary) |
| los_pri | input | 1 | Loss of signal on the primary reference |
| los_sec | input | 1 | Loss of signal on the secondary reference |
| gt_done | input | 1 | Guard-time timer expired |
| ref_sel | output | 1 | Reference-mux select (0 primary, 1 secondary) |
| tie_en | output | 1 | TIE corrector enable, one frame period wide |
| pll_mode | output | 2 | DPLL mode code: 00 Normal, 01 Holdover, 10 Freerun |
| gt_start | output | 1 | Guard-time timer start request |

## Verification
The assertions assume the following about the inputs:
- `frm` is already synchronous to `clk`.
- `frm` stays low for at least one clock between pulses, so that each pulse yields one frame edge.
- The control and loss inputs are meaningful only in a frame-edge cycle.

The bench drives each frame pulse one clock wide, with idle clocks between pulses. It changes the control inputs freely during those idle clocks, which shows that nothing leaks through outside a frame edge. The random frames weight the loss flags and the strap toward automatic control, so the failover and return paths occur often.

// File: rtl/pll_mode_ctrl.sv
module pll_mode_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frm,
  input  logic [1:0] msel,
  input  logic       ref_req,
  input  logic       los_pri,
  input  logic       los_sec,
  input  logic       gt_done,
  output logic       ref_sel,
  output logic       tie_en,
  output logic [1:0] pll_mode,
  output logic       gt_start
);
  localparam logic [1:0] M_NORM = 2'b00;
  localparam logic [1:0] M_HOLD = 2'b01;
  localparam logic [1:0] M_FREE = 2'b10;
  localparam logic [1:0] C_AUTO = 2'b11;

  logic       frm_q;
  logic       fr_edge;
  logic [1:0] nx_mode;
  logic       nx_ref, nx_gt, nx_tie;

  assign fr_edge = frm & ~frm_q;

  always_comb begin
    nx_mode = pll_mode;
    nx_ref  = ref_sel;
    nx_gt   = 1'b0;
    if (msel != C_AUTO) begin
      nx_mode = msel;
      if (msel == M_NORM) nx_ref = ref_req;
    end else if (!los_pri) begin
      nx_mode = M_NORM;
      nx_ref  = 1'b0;
    end else if (!los_sec) begin
      if (pll_mode == M_NORM && ref_sel) begin
        nx_mode = M_NORM;
      end else if (gt_start && gt_done) begin
        nx_mode = M_NORM;
        nx_ref  = 1'b1;
      end else begin
        nx_mode = M_HOLD;
        nx_gt   = 1'b1;
      end
    end else begin
      nx_mode = M_HOLD;
    end
  end

  assign nx_tie = (nx_mode == M_NORM) && (nx_ref != ref_sel);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frm_q    <= 1'b0;
      pll_mode <= M_FREE;
      ref_sel  <= 1'b0;
      tie_en   <= 1'b0;
      gt_start <= 1'b0;
    end else begin
      frm_q <= frm;
      if (fr_edge) begin
        pll_mode <= nx_mode;
        ref_sel  <= nx_ref;
        tie_en   <= nx_tie;
        gt_start <= nx_gt;
      end
    end
  end

  AST_RESET_FREE: assert property (@(posedge clk) $rose(rst_n) |-> pll_mode == M_FREE && !tie_en && !gt_start) else $error("reset state"); // R1
  AST_HOLD_OFF_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    !fr_edge |=> $stable(pll_mode) && $stable(ref_sel) && $stable(tie_en) && $stable(gt_start)) else $error("change off edge"); // R2
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) pll_mode != 2'b11) else $error("illegal mode"); // R3
  AST_MANUAL_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    fr_edge && msel != C_AUTO |=> pll_mode == $past(msel)) else $error("manual mode"); // R3
  AST_AUTO_PRIMARY: assert property (@(posedge clk) disable iff (!rst_n)
    fr_edge && msel == C_AUTO && !los_pri |=> pll_mode == M_NORM && !ref_sel) else $error("auto primary"); // R5
  AST_BOTH_LOST: assert property (@(posedge clk) disable iff (!rst_n)
    fr_edge && msel == C_AUTO && los_pri && los_sec |=> pll_mode == M_HOLD && !gt_start && $stable(ref_sel)) else $error("both lost"); // R8
  AST_TIE_IN_NORMAL: assert property (@(posedge clk) disable iff (!rst_n) tie_en |-> pll_mode == M_NORM) else $error("tie outside normal"); // R9
  AST_GT_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n) gt_start |-> pll_mode == M_HOLD) else $error("gt outside hold"); // R10
endmodule

// File: tb/tb_pll_mode_ctrl.sv
module tb_pll_mode_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, frm = 1'b0;
  logic [1:0] msel = 2'b00;
  logic ref_req = 1'b0, los_pri = 1'b0, los_sec = 1'b0, gt_done = 1'b0;
  logic ref_sel, tie_en, gt_start;
  logic [1:0] pll_mode;

  int n_vec = 0, n_bad = 0;
  logic [1:0] e_mode = 2'b10;
  logic e_ref = 1'b0, e_tie = 1'b0, e_gt = 1'b0;

  pll_mode_ctrl dut (.clk(clk), .rst_n(rst_n), .frm(frm), .msel(msel), .ref_req(ref_req),
    .los_pri(los_pri), .los_sec(los_sec), .gt_done(gt_done), .ref_sel(ref_sel),
    .tie_en(tie_en), .pll_mode(pll_mode), .gt_start(gt_start));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial begin
    #(CLK_PERIOD * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected done)");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  task automatic chk(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string why);
    chk({why, " mode R3 R5 R6 R7 R8"}, pll_mode, e_mode);
    chk({why, " ref R4"}, ref_sel, e_ref);
    chk({why, " tie R9"}, tie_en, e_tie);
    chk({why, " gt R6 R10"}, gt_start, e_gt);
  endtask

  function automatic logic [4:0] model_step(input logic [1:0] ms, input logic rq,
      input logic lp, input logic ls, input logic gd,
      input logic [1:0] md, input logic rf, input logic gs);
    logic [1:0] nm; logic nr, ng, nt;
    nm = md; nr = rf; ng = 1'b0;
    if (ms != 2'b11) begin
      nm = ms;
      if (ms == 2'b00) nr = rq;
    end else if (!lp) begin
      nm = 2'b00; nr = 1'b0;
    end else if (!ls) begin
      if (md == 2'b00 && rf) nm = 2'b00;
      else if (gs && gd) begin nm = 2'b00; nr = 1'b1; end
      else begin nm = 2'b01; ng = 1'b1; end
    end else nm = 2'b01;
    nt = (nm == 2'b00) && (nr != rf);
    return {nm, nr, nt, ng};
  endfunction

  task automatic frame(input logic [1:0] ms, input logic rq, input logic lp,
                       input logic ls, input logic gd, input string why);
    logic [4:0] r;
    @(negedge clk);
    msel = ms; ref_req = rq; los_pri = lp; los_sec = ls; gt_done = gd; frm = 1'b1;
    r = model_step(ms, rq, lp, ls, gd, e_mode, e_ref, e_gt);
    {e_mode, e_ref, e_tie, e_gt} = r;
    @(negedge clk);
    frm = 1'b0;
    chk_all(why);
    for (int i = 0; i < 2; i++) begin
      msel = 2'($urandom); ref_req = 1'($urandom); los_pri = 1'($urandom);
      los_sec = 1'($urandom); gt_done = 1'($urandom);
      @(negedge clk);
      chk_all("idle R2");
    end
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk_all("in reset R1");
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("after release R1");
    frame(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, "manual normal sec R3 R4");
    frame(2'b00, 1'b1, 1'b0, 1'b0, 1'b0, "manual same ref R9");
    frame(2'b01, 1'b0, 1'b0, 1'b0, 1'b0, "manual holdover R4");
    frame(2'b10, 1'b0, 1'b0, 1'b0, 1'b0, "manual freerun R3");
    frame(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, "auto primary R5");
    frame(2'b11, 1'b0, 1'b1, 1'b0, 1'b1, "auto pri lost R6");
    frame(2'b11, 1'b0, 1'b1, 1'b0, 1'b1, "auto guard done R7");
    frame(2'b11, 1'b0, 1'b1, 1'b0, 1'b0, "auto stay sec R7");
    frame(2'b11, 1'b0, 1'b1, 1'b1, 1'b0, "auto both lost R8");
    frame(2'b11, 1'b0, 1'b1, 1'b1, 1'b1, "auto both lost gt R8");
    frame(2'b11, 1'b0, 1'b1, 1'b0, 1'b1, "auto gt without start R6");
    frame(2'b11, 1'b0, 1'b0, 1'b0, 1'b0, "auto hold back pri R9");
    frame(2'b11, 1'b0, 1'b0, 1'b1, 1'b0, "auto return pri R5 R9");
    for (int k = 0; k < 400; k++) begin
      logic [1:0] ms;
      ms = ($urandom % 4 != 0) ? 2'b11 : 2'($urandom % 3);
      frame(ms, 1'($urandom), ($urandom % 3 != 0), ($urandom % 4 == 0),
            1'($urandom), "random R3 R4 R5 R6 R7 R8 R9");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule